// File: doc/BRIEF.md
# Byte-Oriented Serial Register Port

This block is a serial slave that lets an external host program and read back an internal file of byte-wide registers. The host lowers a chip-select line and toggles a serial clock. It sends a start address byte first, then an instruction byte, then the data bytes. On a read, the data bytes come back on a shared open-drain data-out line that has an external pull-up. A static strap selects the bit order within every byte, in both directions.

All four serial inputs pass through synchronizers into the block's own system clock. The block detects the edges of the serial clock in that domain. Towards the chip it drives a simple register bus: address, write data, a one-cycle write strobe and a one-cycle read strobe. The register file returns read data combinationally, in the same cycle as the read strobe. The serial clock idles low. Each half period of the serial clock must last at least four system clocks.

During a block transfer the address moves one register per data byte. It counts up in LSB-first order and down in MSB-first order, and it wraps modulo 256. Once the byte count from the instruction is used up, the port ignores the rest of the cycle. It waits until chip select rises again.

Top module: `serial_regport`

## Requirements
- R1: With msb_first=1, every byte (address, instruction, write data, read data) travels on the wire with bit 7 first. With msb_first=0 it travels with bit 0 first. The numeric value of each byte is the same in both orders.
- R2: While cs_n is high, serial clock edges have no effect. Raising cs_n in the middle of a byte drops the partial byte. The next cycle starts again with an address byte.
- R3: In the numeric value of the instruction byte, bit 7 selects the direction (1 = read, 0 = write) and bits 6:0 give the data byte count N (0 to 127).
- R4: Each written data byte gives exactly one single-cycle reg_wr pulse. During that pulse, reg_wdata holds the byte and reg_addr holds its target address.
- R5: The first data byte goes to the address from the address byte. Each later byte goes one address higher when msb_first=0, or one address lower when msb_first=1, wrapping modulo 256.
- R6: A read gives exactly one single-cycle reg_rd pulse per data byte. The first pulse comes right after the instruction byte. The data bits change after falling serial clock edges. The first bit is valid before the first rising edge of the data phase, so the host samples each bit at a rising edge.
- R7: If N=0, no data is moved. After N data bytes, further clocks cause no strobe and no drive on SDO until cs_n has been high.
- R8: sdo_oe (1 = pull SDO low) is high only while a read data bit of value 0 is presented. At all other times the line is released.
- R9: reg_wr and reg_rd are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msb_first | input | 1 | Bit-order strap: 1 = bit 7 first, 0 = bit 0 first |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo_oe | output | 1 | Open-drain pull-down enable for serial data out |
| reg_addr | output | 8 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data, valid in the reg_rd cycle |

## Verification
Each internal fault shows up at the ports within a short, known time.
- A wrong bit counter or byte phase shifts every later field. Writes then land at the wrong address or with rotated data, and this shows in the register contents after that same transaction.
- A wrong address step shows as a wrong register being touched at the next byte. A read-back then returns the value that belongs to a neighbouring register.
- A bad remaining-byte count or a stale state after chip select shows in a strobe count above or below N. It also shows when overrun bytes are written, or when SDO is pulled low during bytes that should return all ones.

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msb_first,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata
);
  localparam int TOP = SYNC_STAGES - 1;

  typedef enum logic [1:0] {PH_ADDR, PH_INSTR, PH_DATA, PH_DONE} phase_t;

  logic [TOP:0] cs_pipe, sclk_pipe, sdi_pipe;
  logic         sclk_d;
  logic         cs_q, sclk_s, sdi_s, rise, fall, byte_done;
  phase_t       phase;
  logic [2:0]   bit_cnt;
  logic [7:0]   sh, next_sh, tx, addr, wdata, step_addr;
  logic [6:0]   left;
  logic         rw, wr_q, rd_q, drive, sdo_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_pipe   <= '1;
      sclk_pipe <= '0;
      sdi_pipe  <= '0;
      sclk_d    <= 1'b0;
    end else begin
      cs_pipe   <= {cs_pipe[TOP-1:0], cs_n};
      sclk_pipe <= {sclk_pipe[TOP-1:0], sclk};
      sdi_pipe  <= {sdi_pipe[TOP-1:0], sdi};
      sclk_d    <= sclk_pipe[TOP];
    end

  assign cs_q      = cs_pipe[TOP];
  assign sclk_s    = sclk_pipe[TOP];
  assign sdi_s     = sdi_pipe[TOP];
  assign rise      = !cs_q && sclk_s && !sclk_d;
  assign fall      = !cs_q && !sclk_s && sclk_d;
  assign byte_done = rise && bit_cnt == 3'd7 && phase != PH_DONE;
  assign next_sh   = msb_first ? {sh[6:0], sdi_s} : {sdi_s, sh[7:1]};
  assign step_addr = msb_first ? addr - 8'd1 : addr + 8'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      sh      <= '0;
      tx      <= '0;
      addr    <= '0;
      wdata   <= '0;
      left    <= '0;
      rw      <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      drive   <= 1'b0;
      sdo_bit <= 1'b1;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (wr_q) addr <= step_addr;
      if (cs_q) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        left    <= '0;
        drive   <= 1'b0;
        sdo_bit <= 1'b1;
      end else begin
        if (rise && phase != PH_DONE) begin
          sh      <= next_sh;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done)
          case (phase)
            PH_ADDR: begin
              addr  <= next_sh;
              phase <= PH_INSTR;
            end
            PH_INSTR: begin
              rw   <= next_sh[7];
              left <= next_sh[6:0];
              if (next_sh[6:0] == 7'd0) phase <= PH_DONE;
              else begin
                phase <= PH_DATA;
                rd_q  <= next_sh[7];
              end
            end
            PH_DATA: begin
              left <= left - 7'd1;
              if (left == 7'd1) phase <= PH_DONE;
              if (!rw) begin
                wr_q  <= 1'b1;
                wdata <= next_sh;
              end else begin
                addr <= step_addr;
                if (left != 7'd1) rd_q <= 1'b1;
              end
            end
            default: ;
          endcase
        if (fall && phase == PH_DATA && rw) begin
          drive   <= 1'b1;
          sdo_bit <= msb_first ? tx[7] : tx[0];
          tx      <= msb_first ? {tx[6:0], 1'b0} : {1'b0, tx[7:1]};
        end else if (fall || phase == PH_DONE) begin
          drive <= 1'b0;
        end
      end
      if (rd_q) tx <= reg_rdata;
    end

  assign sdo_oe    = drive && !sdo_bit && !cs_q;
  assign reg_addr  = addr;
  assign reg_wdata = wdata;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_wr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == ($past(msb_first) ? $past(reg_addr) - 8'd1
                                             : $past(reg_addr) + 8'd1));

  assert_idle_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !reg_wr && !reg_rd && !sdo_oe);

  assert_sdo_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rw && (phase == PH_DATA || phase == PH_DONE));
endmodule

// File: tb/serial_regport_test.sv
`timescale 1ns/1ps
module serial_regport_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msb_first = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       sdo_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] tx_buf [136];
  logic [7:0] rx_buf [136];
  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_regport uut (
    .clk(clk), .rst_n(rst_n), .msb_first(msb_first), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
      if (reg_wr && reg_rd) both_cnt <= both_cnt + 1;
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic o);
    sdi = b;
    #50;
    o = ~sdo_oe;
    sclk = 1'b1;
    #50;
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic [7:0] r);
    logic o;
    for (int i = 0; i < 8; i++) begin
      int idx = msb_first ? 7 - i : i;
      bit_xfer(v[idx], o);
      r[idx] = o;
    end
  endtask

  task automatic xact(input logic msb, input logic [7:0] a, input logic rd,
                      input int n, input int extra);
    logic [7:0] dummy;
    msb_first = msb;
    #20;
    wr_cnt = 0;
    rd_cnt = 0;
    cs_n = 1'b0;
    #50;
    send_byte(a, dummy);
    send_byte({rd, 7'(n)}, dummy);
    for (int k = 0; k < n + extra; k++) send_byte(tx_buf[k], rx_buf[k]);
    #50;
    cs_n = 1'b1;
    #100;
  endtask

  function automatic logic [7:0] addr_at(input logic msb, input logic [7:0] a, input int k);
    return msb ? 8'(a - 8'(k)) : 8'(a + 8'(k));
  endfunction

  task automatic compare_mem(input string tag);
    int bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    check(bad < 0, tag, bad < 0 ? 0 : int'(mem[bad]), bad < 0 ? 0 : int'(exp_mem[bad]));
  endtask

  task automatic write_then_read(input logic msb, input logic [7:0] a, input int n, input int seed);
    int bad = -1;
    for (int k = 0; k < n; k++) tx_buf[k] = 8'(k * 13 + seed * 7 + 3);
    xact(msb, a, 1'b0, n, 0);
    check(wr_cnt == n, "R4 write strobe count", wr_cnt, n);
    for (int k = 0; k < n; k++) exp_mem[addr_at(msb, a, k)] = tx_buf[k];
    compare_mem(msb ? "R1/R5 msb-first write contents" : "R1/R5 lsb-first write contents");
    xact(msb, a, 1'b1, n, 0);
    check(rd_cnt == n, "R6 read strobe count", rd_cnt, n);
    check(wr_cnt == 0, "R3 read does not write", wr_cnt, 0);
    for (int k = 0; k < n; k++)
      if (bad < 0 && rx_buf[k] !== exp_mem[addr_at(msb, a, k)]) bad = k;
    check(bad < 0, "R6 read data on SDO", bad < 0 ? 0 : int'(rx_buf[bad]),
          bad < 0 ? 0 : int'(exp_mem[addr_at(msb, a, bad)]));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens [5] = '{1, 2, 3, 8, 127};
    logic [7:0] dummy;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
    #42;
    rst_n = 1'b1;
    #40;
    check(sdo_oe == 1'b0, "R8 reset sdo released", sdo_oe, 0);
    check(reg_wr == 1'b0 && reg_rd == 1'b0, "R4/R6 reset strobes idle", {reg_wr, reg_rd}, 0);

    for (int m = 0; m < 2; m++)
      for (int li = 0; li < 5; li++) begin
        logic [7:0] start = 8'(lens[li] * 37 + m * 101);
        write_then_read(m[0], start, lens[li], li + m * 5);
      end

    write_then_read(1'b0, 8'hFC, 8, 11);
    write_then_read(1'b1, 8'h03, 8, 12);
    write_then_read(1'b0, 8'hFF, 1, 13);
    write_then_read(1'b1, 8'h00, 2, 14);

    for (int k = 0; k < 3; k++) tx_buf[k] = 8'hC3 + 8'(k);
    xact(1'b0, 8'h20, 1'b0, 0, 3);
    check(wr_cnt == 0, "R7 N=0 write moves nothing", wr_cnt, 0);
    compare_mem("R7 N=0 write leaves registers");
    xact(1'b1, 8'h20, 1'b1, 0, 2);
    check(rd_cnt == 0, "R7 N=0 read issues no strobe", rd_cnt, 0);
    check(rx_buf[0] == 8'hFF && rx_buf[1] == 8'hFF, "R8 SDO released on N=0 read",
          {rx_buf[0], rx_buf[1]}, 16'hFFFF);

    for (int k = 0; k < 5; k++) tx_buf[k] = 8'h90 + 8'(k);
    xact(1'b1, 8'h50, 1'b0, 2, 3);
    check(wr_cnt == 2, "R7 overrun write strobes", wr_cnt, 2);
    exp_mem[8'h50] = 8'h90;
    exp_mem[8'h4F] = 8'h91;
    compare_mem("R7 overrun bytes ignored");
    xact(1'b0, 8'h4F, 1'b1, 2, 2);
    check(rd_cnt == 2, "R7 overrun read strobes", rd_cnt, 2);
    check(rx_buf[0] == 8'h91 && rx_buf[1] == 8'h90 && rx_buf[2] == 8'hFF && rx_buf[3] == 8'hFF,
          "R7 overrun read data then released", {rx_buf[0], rx_buf[1], rx_buf[2], rx_buf[3]},
          32'h9190FFFF);

    msb_first = 1'b1;
    cs_n = 1'b0;
    #50;
    send_byte(8'h77, dummy);
    for (int i = 0; i < 3; i++) begin
      logic o;
      bit_xfer(1'b1, o);
    end
    #50;
    cs_n = 1'b1;
    #100;
    tx_buf[0] = 8'h3C;
    xact(1'b1, 8'h10, 1'b0, 1, 0);
    check(wr_cnt == 1, "R2 abort then write strobe count", wr_cnt, 1);
    exp_mem[8'h10] = 8'h3C;
    compare_mem("R2 abort leaves no partial framing");

    wr_cnt = 0;
    for (int i = 0; i < 24; i++) begin
      sclk = 1'b1; sdi = ~sdi; #50;
      sclk = 1'b0; #50;
    end
    check(wr_cnt == 0 && rd_cnt == 0, "R2 clocks ignored while deselected", wr_cnt + rd_cnt, 0);
    check(sdo_oe == 1'b0, "R8 sdo released while deselected", sdo_oe, 0);
    compare_mem("R2 registers unchanged while deselected");
    check(both_cnt == 0, "R9 strobes never together", both_cnt, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule